// File: doc/BRIEF.md
# Targeted Core Reset Controller

This block lets any processor core on a chip reset any core, itself included, with one register write. Each core owns a small write port that carries a 4-bit target core identifier. When a write names an implemented core, the controller raises that core's reset output. It holds the output for a fixed number of clock cycles and then releases it without any further action from software.

Each core also has a reset-cause bit that the core can read after it comes out of reset. The bit is cleared by a system reset and set by a targeted reset. Software can therefore tell a power-on or board-level restart apart from a restart ordered by a peer core. The controller itself is cleared only by the system reset, so a core that resets itself does not lose the record of why it went down.

The default build has two cores with identifiers 0 and 1 and a 16-cycle pulse. The core count and the pulse width are both parameters.

Top module: `tcr_core_reset_ctrl`

## Requirements
- R1: While `sys_rst` is high, every bit of `core_rst_o` is high. All pulse timers are cleared, so in the cycle after `sys_rst` falls no reset output is high unless a request was taken in that same edge.
- R2: Suppose core j has `wr_en[j]` high at a rising edge and `wr_id[j*4 +: 4]` equals an implemented core number i. Then `core_rst_o[i]` is high for exactly PULSE_CYCLES cycles, starting right after that edge, and then falls by itself.
- R3: A core may name its own identifier. The pulse then goes to its own reset output, with the same timing as R2.
- R4: A write whose 4-bit identifier is NUM_CORES or more (2 to 15 by default) has no effect on any reset output or cause bit.
- R5: A new request to a core whose pulse is still running restarts the count. The output stays high for PULSE_CYCLES cycles after the later request.
- R6: `rst_cause_o[i]` becomes 1 in the cycle after a request to core i is taken. It stays 1 through the pulse and afterwards, until the next system reset.
- R7: In the cycle after any edge where `sys_rst` is high, every bit of `rst_cause_o` is 0, even if a request arrived in that cycle.
- R8: Requests from several cores in the same cycle are all taken. Each named core gets its pulse, and two requests that name the same core give one ordinary pulse.
- R9: The identifier field of core j occupies bits `[j*4 +: 4]` of `wr_id`. When `wr_en[j]` is low, that field is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| sys_rst | input | 1 | Synchronous active-high system reset |
| wr_en | input | NUM_CORES | Per-core write strobe for the reset-target register |
| wr_id | input | NUM_CORES*4 | Per-core 4-bit target identifier, core j in bits [j*4 +: 4] |
| core_rst_o | output | NUM_CORES | Per-core reset output, active high |
| rst_cause_o | output | NUM_CORES | Per-core cause bit: 0 after system reset, 1 after targeted reset |

## Verification
Two pairs of functions can meet in one cycle: two cores writing requests together, and a new request arriving while a pulse is already counting down. The bench forces both pairs directly. Both cores name the same target, both name different targets, and a request is re-sent halfway through a pulse. The random phase also produces them, along with system resets that land on top of writes. A cycle-by-cycle model in the bench judges each case: it reloads the count on every request, merges hits from all writers, and lets the system reset win over any write.

// File: rtl/tcr_pkg.sv
package tcr_pkg;
    localparam int unsigned ID_W = 4;

    typedef logic [ID_W-1:0] core_id_t;

    typedef struct packed {
        logic     valid;
        core_id_t id;
    } rst_req_t;

    function automatic logic req_hits(rst_req_t r, int unsigned core);
        return r.valid && (r.id == core_id_t'(core));
    endfunction
endpackage

// File: rtl/tcr_req_merge.sv
module tcr_req_merge
    import tcr_pkg::*;
#(
    parameter int unsigned NUM_CORES = 2
) (
    input  rst_req_t [NUM_CORES-1:0] req_i,
    output logic     [NUM_CORES-1:0] hit_o
);
    always_comb begin
        hit_o = '0;
        for (int unsigned t = 0; t < NUM_CORES; t++) begin
            for (int unsigned s = 0; s < NUM_CORES; s++) begin
                if (req_hits(req_i[s], t)) hit_o[t] = 1'b1;
            end
        end
    end

    // R4 / R9: no valid request means no target is hit
    always_comb begin
        automatic logic any_valid = 1'b0;
        for (int unsigned s = 0; s < NUM_CORES; s++) any_valid |= req_i[s].valid;
        if (!any_valid) assert_idle_no_hit_R9: assert (hit_o == '0);
    end
endmodule

// File: rtl/tcr_pulse_timer.sv
module tcr_pulse_timer #(
    parameter int unsigned PULSE_CYCLES = 16,
    localparam int unsigned CNT_W = $clog2(PULSE_CYCLES + 1)
) (
    input  logic clk,
    input  logic sys_rst,
    input  logic hit_i,
    output logic busy_o
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (sys_rst)            cnt_q <= '0;
        else if (hit_i)         cnt_q <= CNT_W'(PULSE_CYCLES);
        else if (cnt_q != '0)   cnt_q <= cnt_q - CNT_W'(1);
    end

    assign busy_o = (cnt_q != '0);

    assert_hit_starts_R2: assert property (@(posedge clk) disable iff (sys_rst)
        hit_i |=> busy_o);

    assert_countdown_R5: assert property (@(posedge clk) disable iff (sys_rst)
        (busy_o && !hit_i) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

    assert_sysrst_clears_R1: assert property (@(posedge clk)
        sys_rst |=> (cnt_q == '0 || $past(hit_i)) );
endmodule

// File: rtl/tcr_cause_reg.sv
module tcr_cause_reg (
    input  logic clk,
    input  logic sys_rst,
    input  logic hit_i,
    output logic cause_o
);
    always_ff @(posedge clk) begin
        if (sys_rst)     cause_o <= 1'b0;
        else if (hit_i)  cause_o <= 1'b1;
    end

    assert_cause_set_R6: assert property (@(posedge clk) disable iff (sys_rst)
        hit_i |=> cause_o);

    assert_cause_sticky_R6: assert property (@(posedge clk) disable iff (sys_rst)
        cause_o |=> cause_o);

    assert_cause_cleared_R7: assert property (@(posedge clk)
        sys_rst |=> !cause_o);
endmodule

// File: rtl/tcr_core_reset_ctrl.sv
module tcr_core_reset_ctrl
    import tcr_pkg::*;
#(
    parameter int unsigned NUM_CORES    = 2,
    parameter int unsigned PULSE_CYCLES = 16
) (
    input  logic                      clk,
    input  logic                      sys_rst,
    input  logic [NUM_CORES-1:0]      wr_en,
    input  logic [NUM_CORES*ID_W-1:0] wr_id,
    output logic [NUM_CORES-1:0]      core_rst_o,
    output logic [NUM_CORES-1:0]      rst_cause_o
);
    rst_req_t [NUM_CORES-1:0] req;
    logic     [NUM_CORES-1:0] hit;
    logic     [NUM_CORES-1:0] busy;

    for (genvar j = 0; j < NUM_CORES; j++) begin : g_req
        assign req[j].valid = wr_en[j];
        assign req[j].id    = wr_id[j*ID_W +: ID_W];
    end

    tcr_req_merge #(.NUM_CORES(NUM_CORES)) u_merge (
        .req_i (req),
        .hit_o (hit)
    );

    for (genvar i = 0; i < NUM_CORES; i++) begin : g_core
        tcr_pulse_timer #(.PULSE_CYCLES(PULSE_CYCLES)) u_timer (
            .clk     (clk),
            .sys_rst (sys_rst),
            .hit_i   (hit[i]),
            .busy_o  (busy[i])
        );
        tcr_cause_reg u_cause (
            .clk     (clk),
            .sys_rst (sys_rst),
            .hit_i   (hit[i]),
            .cause_o (rst_cause_o[i])
        );
    end

    assign core_rst_o = busy | {NUM_CORES{sys_rst}};

    assert_sysrst_drives_all_R1: assert property (@(posedge clk)
        sys_rst |-> (core_rst_o == {NUM_CORES{1'b1}}));

    assert_pulse_holds_R2: assert property (@(posedge clk) disable iff (sys_rst)
        (hit != '0) |=> ((core_rst_o & $past(hit)) == $past(hit)));
endmodule

// File: tb/tcr_core_reset_ctrl_bench.sv
module tcr_core_reset_ctrl_bench;
    localparam int unsigned N     = 2;
    localparam int unsigned P     = 16;
    localparam int unsigned IDW   = 4;
    localparam time         CLK_T = 10;

    logic               clk = 1'b0;
    logic               sys_rst;
    logic [N-1:0]       wr_en;
    logic [N*IDW-1:0]   wr_id;
    logic [N-1:0]       core_rst_o;
    logic [N-1:0]       rst_cause_o;

    int checks = 0;
    int fails  = 0;
    int m_cnt   [N];
    bit m_cause [N];

    always #(CLK_T/2) clk = ~clk;

    tcr_core_reset_ctrl #(.NUM_CORES(N), .PULSE_CYCLES(P)) u_tcr_core_reset_ctrl (
        .clk (clk), .sys_rst (sys_rst), .wr_en (wr_en), .wr_id (wr_id),
        .core_rst_o (core_rst_o), .rst_cause_o (rst_cause_o)
    );

    function automatic bit model_hit(int unsigned tgt, logic [N-1:0] en, logic [N*IDW-1:0] ids);
        for (int s = 0; s < N; s++)
            if (en[s] && ids[s*IDW +: IDW] == IDW'(tgt)) return 1'b1;
        return 1'b0;
    endfunction

    function automatic logic [N-1:0] exp_rst(bit r);
        logic [N-1:0] v;
        for (int i = 0; i < N; i++) v[i] = r || (m_cnt[i] != 0);
        return v;
    endfunction

    function automatic logic [N-1:0] exp_cause();
        logic [N-1:0] v;
        for (int i = 0; i < N; i++) v[i] = m_cause[i];
        return v;
    endfunction

    task automatic check(string tag, string what, logic [N-1:0] act, logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%b expected=%b t=%0t", tag, what, act, exp, $time);
        end
    endtask

    // one clock: drive at negedge, update model at the edge, check just after
    task automatic cycle(string tag, bit r, logic [N-1:0] en, logic [N*IDW-1:0] ids);
        @(negedge clk);
        sys_rst = r; wr_en = en; wr_id = ids;
        @(posedge clk);
        for (int i = 0; i < N; i++) begin
            if (r) begin m_cnt[i] = 0; m_cause[i] = 1'b0; end
            else if (model_hit(i, en, ids)) begin m_cnt[i] = P; m_cause[i] = 1'b1; end
            else if (m_cnt[i] != 0) m_cnt[i]--;
        end
        #1;
        check(tag, "core_rst_o", core_rst_o, exp_rst(r));
        check(tag, "rst_cause_o", rst_cause_o, exp_cause());
    endtask

    task automatic idle(string tag, int n);
        for (int k = 0; k < n; k++) cycle(tag, 1'b0, '0, '0);
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        #(CLK_T * 200000);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int pulse_len;
        void'($urandom(32'd2024));
        sys_rst = 1'b1; wr_en = '0; wr_id = '0;
        for (int i = 0; i < N; i++) begin m_cnt[i] = 0; m_cause[i] = 0; end

        // R1 / R7: system reset holds all outputs and clears causes
        for (int k = 0; k < 3; k++) cycle("R1", 1'b1, '0, '0);
        cycle("R7", 1'b0, '0, '0);

        // R2: core 0 targets core 1; measure pulse length at the port
        cycle("R2", 1'b0, 2'b01, {4'd0, 4'd1});
        pulse_len = core_rst_o[1] ? 1 : 0;
        for (int k = 0; k < P + 3; k++) begin
            cycle("R2", 1'b0, '0, '0);
            if (core_rst_o[1]) pulse_len++;
        end
        checks++;
        if (pulse_len != P) begin
            fails++;
            $display("FAIL R2 pulse length actual=%0d expected=%0d", pulse_len, P);
        end

        // R6: cause remains set long after the pulse
        idle("R6", 5);

        // R3: core 1 resets itself
        cycle("R3", 1'b0, 2'b10, {4'd1, 4'd0});
        idle("R3", P + 2);

        // R4: unimplemented identifiers from both writers
        cycle("R1", 1'b1, '0, '0);
        for (int v = N; v < 16; v++) cycle("R4", 1'b0, 2'b11, {IDW'(v), IDW'(15 - v + N)});
        idle("R4", 2);

        // R5: retrigger core 0 halfway through its pulse
        cycle("R5", 1'b0, 2'b01, {4'd0, 4'd0});
        idle("R5", P / 2);
        cycle("R5", 1'b0, 2'b10, {4'd0, 4'd0});
        idle("R5", P + 2);

        // R8: both writers, different targets, then same target
        cycle("R8", 1'b0, 2'b11, {4'd0, 4'd1});
        idle("R8", P + 1);
        cycle("R8", 1'b0, 2'b11, {4'd1, 4'd1});
        idle("R8", P + 1);

        // R9: matching identifiers with strobes low do nothing
        cycle("R1", 1'b1, '0, '0);
        for (int k = 0; k < 4; k++) cycle("R9", 1'b0, 2'b00, {4'd1, 4'd0});

        // R7: system reset wins over a simultaneous write
        cycle("R7", 1'b1, 2'b11, {4'd0, 4'd1});
        cycle("R7", 1'b0, '0, '0);

        // random mix with the same model
        for (int k = 0; k < 3000; k++) begin
            logic [N*IDW-1:0] ids;
            logic [N-1:0]     en;
            for (int s = 0; s < N; s++)
                ids[s*IDW +: IDW] = ($urandom % 4 == 0) ? IDW'($urandom % 16) : IDW'($urandom % N);
            en = ($urandom % 3 == 0) ? N'($urandom) : '0;
            cycle("R8", ($urandom % 97 == 0), en, ids);
        end

        finish_run();
    end
endmodule